// File: doc/BRIEF.md
# Multi-drop Serial Character Receiver with Address Filtering

This block receives asynchronous serial characters from one line shared by several nodes. It synchronizes the line and samples each bit at its centre using a baud tick that runs at sixteen times the bit rate. It assembles 8-bit or 9-bit characters and moves each finished character into a two-entry buffer. A reader drains that buffer through a valid/ready handshake.

An address-detect mode serves multi-drop protocols. In this mode the ninth bit marks address characters, and every character with a clear ninth bit is dropped before it reaches the buffer. Software turns the filter off once its own address has been seen, so that the data characters that follow are let through.

The block also reports three conditions. A sticky overrun flag is set when a character arrives with nowhere to go. Each buffered character carries its own framing-error bit. A receive-idle indication shows whether a frame is in progress.

Top module: `uart_addr_rx`

## Requirements
- R1: A frame is a low start bit, then data bits least significant first, then a high stop bit. Each bit lasts 16 baud ticks. Its value is the majority of three samples taken at ticks 7, 8 and 9 of the bit, counted from the tick on which the start edge is detected. In 8-bit mode the character's 8 data bits appear on `out_data_o`.
- R2: Reception runs only while `port_en_i` is 1, `sync_mode_i` is 0 and `rx_en_i` is 1. Otherwise the line is ignored and `rx_idle_o` stays 1.
- R3: When `nine_bit_i` is 1, a ninth data bit follows bit 7 and appears on `out_bit9_o`. The low eight bits appear on `out_data_o`. In 8-bit mode `out_bit9_o` is 0.
- R4: When `nine_bit_i` and `addr_det_i` are both 1, a character whose ninth bit is 0 is dropped: it neither enters the buffer nor raises `out_valid_o`. With `addr_det_i` at 0, every character is buffered.
- R5: The buffer holds two characters in arrival order. `out_valid_o`, the receive flag, is 1 while the buffer is not empty. A cycle with `out_valid_o` and `out_ready_i` both 1 pops the head entry. While no pop occurs, the head entry holds steady.
- R6: `irq_o` is 1 exactly when `out_valid_o` and `rx_ie_i` are both 1.
- R7: A character that would be buffered while the buffer already holds two entries sets `overrun_o` and is discarded. This holds even if a pop happens in the same cycle. While `overrun_o` is 1, every new character is discarded and the buffered entries are kept.
- R8: `overrun_o` stays 1 while `rx_en_i` is 1. It is cleared only on the clock after `rx_en_i` is 0.
- R9: A stop bit sampled low sets `out_ferr_o` for that character while it is the head entry.
- R10: A start bit whose centre vote is high is a glitch. The receiver returns to idle and buffers nothing.
- R11: `rx_idle_o` is 0 from start detection until the frame ends, and 1 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_i | input | 1 | Serial line, idle high |
| baud_tick_i | input | 1 | One-cycle pulse at 16x the bit rate |
| port_en_i | input | 1 | Serial port enable |
| sync_mode_i | input | 1 | Synchronous mode select (must be 0 to receive) |
| rx_en_i | input | 1 | Continuous receive enable; 0 clears overrun |
| nine_bit_i | input | 1 | 9-bit character mode |
| addr_det_i | input | 1 | Address-detect filter enable (9-bit mode only) |
| rx_ie_i | input | 1 | Receive interrupt enable |
| out_valid_o | output | 1 | Buffer not empty (receive flag) |
| out_ready_i | input | 1 | Reader accepts the head entry |
| out_data_o | output | 8 | Head entry low eight bits |
| out_bit9_o | output | 1 | Head entry ninth bit |
| out_ferr_o | output | 1 | Head entry framing error |
| overrun_o | output | 1 | Sticky overrun |
| rx_idle_o | output | 1 | No frame in progress |
| irq_o | output | 1 | Receive interrupt request |

## Verification
The assertions assume that `nine_bit_i` and `addr_det_i` do not change while a frame is in progress. They also assume that `baud_tick_i` is a single-cycle pulse, so that the tick count and the sample positions stay consistent. The stimulus changes mode inputs only while `rx_idle_o` is 1. It ticks every clock and holds each line level for exactly 16 ticks. Between frames it drives the line high for long enough that no stop bit runs into the next start edge.

// File: rtl/uarx_pkg.sv
package uarx_pkg;
  typedef struct packed {
    logic       ferr;
    logic       bit9;
    logic [7:0] data;
  } rx_char_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_STOP
  } rx_state_e;
endpackage

// File: rtl/uarx_sync.sv
module uarx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '1;
    else        pipe_q <= {pipe_q[STAGES-2:0], d_i};
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/uarx_frame.sv
module uarx_frame
  import uarx_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     active_i,
  input  logic     nine_bit_i,
  input  logic     tick_i,
  input  logic     rxd_i,
  output logic     done_o,
  output rx_char_t char_o,
  output logic     idle_o
);
  localparam int CW  = $clog2(OSR);
  localparam int MID = OSR / 2;

  rx_state_e      state_q;
  logic [CW-1:0]  cnt_q;
  logic [3:0]     bitn_q;
  logic [8:0]     shreg_q;
  logic [1:0]     votes_q;
  logic           vote;
  logic           in_window;
  logic           vote_now;
  logic           bit_end;
  logic [3:0]     last_bit;

  assign vote      = (votes_q[1] & votes_q[0]) | (votes_q[1] & rxd_i) | (votes_q[0] & rxd_i);
  assign in_window = (cnt_q >= CW'(MID - 1)) && (cnt_q <= CW'(MID + 1));
  assign vote_now  = (cnt_q == CW'(MID + 1));
  assign bit_end   = (cnt_q == CW'(OSR - 1));
  assign last_bit  = nine_bit_i ? 4'd8 : 4'd7;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      bitn_q  <= '0;
      shreg_q <= '0;
      votes_q <= '0;
      done_o  <= 1'b0;
      char_o  <= '0;
    end else if (!active_i) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (tick_i) begin
        if (in_window) votes_q <= {votes_q[0], rxd_i};
        case (state_q)
          ST_IDLE: begin
            if (!rxd_i) begin
              state_q <= ST_START;
              cnt_q   <= CW'(1);
            end
          end
          ST_START: begin
            cnt_q <= cnt_q + 1'b1;
            if (vote_now && vote) state_q <= ST_IDLE;
            else if (bit_end) begin
              cnt_q   <= '0;
              bitn_q  <= '0;
              state_q <= ST_DATA;
            end
          end
          ST_DATA: begin
            cnt_q <= cnt_q + 1'b1;
            if (vote_now) shreg_q <= {vote, shreg_q[8:1]};
            if (bit_end) begin
              cnt_q <= '0;
              if (bitn_q == last_bit) state_q <= ST_STOP;
              else                    bitn_q  <= bitn_q + 1'b1;
            end
          end
          default: begin
            cnt_q <= cnt_q + 1'b1;
            if (vote_now) begin
              done_o      <= 1'b1;
              char_o.ferr <= ~vote;
              char_o.data <= nine_bit_i ? shreg_q[7:0] : shreg_q[8:1];
              char_o.bit9 <= nine_bit_i & shreg_q[8];
              state_q     <= ST_IDLE;
            end
          end
        endcase
      end
    end
  end

  assign idle_o = (state_q == ST_IDLE);

  // R2
  inactive_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active_i |=> idle_o);
endmodule

// File: rtl/uarx_fifo.sv
module uarx_fifo
  import uarx_pkg::*;
#(
  parameter int DEPTH = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push_i,
  input  rx_char_t        push_data_i,
  input  logic            pop_i,
  output logic            full_o,
  output logic            valid_o,
  output logic [$clog2(DEPTH):0] count_o,
  output rx_char_t        head_o
);
  localparam int AW = $clog2(DEPTH);

  rx_char_t        mem_q [DEPTH];
  logic [AW-1:0]   wr_q, rd_q;
  logic [AW:0]     cnt_q;
  logic            do_push, do_pop;

  assign do_push = push_i && (cnt_q != (AW+1)'(DEPTH));
  assign do_pop  = pop_i && (cnt_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else begin
      if (do_push) begin
        mem_q[wr_q] <= push_data_i;
        wr_q <= (wr_q == AW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
      end
      if (do_pop) rd_q <= (rd_q == AW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign full_o  = (cnt_q == (AW+1)'(DEPTH));
  assign valid_o = (cnt_q != '0);
  assign count_o = cnt_q;
  assign head_o  = mem_q[rd_q];

  // R5
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= (AW+1)'(DEPTH));
  // R5
  head_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !pop_i) |=> $stable(head_o));
endmodule

// File: rtl/uart_addr_rx.sv
module uart_addr_rx
  import uarx_pkg::*;
#(
  parameter int OSR   = 16,
  parameter int DEPTH = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_i,
  input  logic       baud_tick_i,
  input  logic       port_en_i,
  input  logic       sync_mode_i,
  input  logic       rx_en_i,
  input  logic       nine_bit_i,
  input  logic       addr_det_i,
  input  logic       rx_ie_i,
  output logic       out_valid_o,
  input  logic       out_ready_i,
  output logic [7:0] out_data_o,
  output logic       out_bit9_o,
  output logic       out_ferr_o,
  output logic       overrun_o,
  output logic       rx_idle_o,
  output logic       irq_o
);
  localparam int CNTW = $clog2(DEPTH) + 1;

  logic          rxd;
  logic          active;
  logic          done;
  rx_char_t      rx_char;
  rx_char_t      head;
  logic          accept;
  logic          push;
  logic          pop;
  logic          full;
  logic [CNTW-1:0] fifo_count;
  logic          overrun_q;

  assign active = port_en_i & ~sync_mode_i & rx_en_i;

  uarx_sync #(.STAGES(2)) i_sync (
    .clk(clk), .rst_n(rst_n), .d_i(rx_i), .q_o(rxd)
  );

  uarx_frame #(.OSR(OSR)) i_frame (
    .clk(clk), .rst_n(rst_n), .active_i(active), .nine_bit_i(nine_bit_i),
    .tick_i(baud_tick_i), .rxd_i(rxd), .done_o(done), .char_o(rx_char),
    .idle_o(rx_idle_o)
  );

  assign accept = done & (~(nine_bit_i & addr_det_i) | rx_char.bit9);
  assign push   = accept & ~overrun_q & ~full;
  assign pop    = out_valid_o & out_ready_i;

  uarx_fifo #(.DEPTH(DEPTH)) i_fifo (
    .clk(clk), .rst_n(rst_n), .push_i(push), .push_data_i(rx_char),
    .pop_i(pop), .full_o(full), .valid_o(out_valid_o), .count_o(fifo_count),
    .head_o(head)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             overrun_q <= 1'b0;
    else if (!rx_en_i)      overrun_q <= 1'b0;
    else if (accept && full) overrun_q <= 1'b1;
  end

  assign overrun_o  = overrun_q;
  assign out_data_o = head.data;
  assign out_bit9_o = head.bit9;
  assign out_ferr_o = head.ferr;
  assign irq_o      = out_valid_o & rx_ie_i;

  // R8
  overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun_o && rx_en_i) |=> overrun_o);
  // R8
  overrun_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en_i |=> !overrun_o);
  // R7
  overrun_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun_o && !pop) |=> $stable(fifo_count));
endmodule

// File: tb/test_uart_addr_rx.sv
module test_uart_addr_rx;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx = 1'b1, tick = 1'b1;
  logic port_en = 1'b1, sync_mode = 1'b0, rx_en = 1'b1;
  logic nine_bit = 1'b0, addr_det = 1'b0, rx_ie = 1'b0, ready = 1'b0;
  logic valid, bit9, ferr, overrun, idle, irq;
  logic [7:0] data;
  logic mid_idle;
  int checks = 0, errors = 0, cycles = 0;

  always #4 clk = ~clk;

  uart_addr_rx i_uart_addr_rx (
    .clk(clk), .rst_n(rst_n), .rx_i(rx), .baud_tick_i(tick),
    .port_en_i(port_en), .sync_mode_i(sync_mode), .rx_en_i(rx_en),
    .nine_bit_i(nine_bit), .addr_det_i(addr_det), .rx_ie_i(rx_ie),
    .out_valid_o(valid), .out_ready_i(ready), .out_data_o(data),
    .out_bit9_o(bit9), .out_ferr_o(ferr), .overrun_o(overrun),
    .rx_idle_o(idle), .irq_o(irq)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic hold(input logic lvl, input int n);
    rx = lvl;
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [8:0] val, input bit nine, input bit stop_ok);
    @(negedge clk);
    hold(1'b0, 16);
    hold(val[0], 8);
    mid_idle = idle;
    hold(val[0], 8);
    for (int i = 1; i < (nine ? 9 : 8); i++) hold(val[i], 16);
    hold(stop_ok, 16);
    hold(1'b1, 24);
  endtask

  task automatic pop_one();
    @(negedge clk); ready = 1'b1;
    @(negedge clk); ready = 1'b0;
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 190000);
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(valid == 0 && overrun == 0 && irq == 0, "reset valid", valid, 0);
    check(idle == 1, "R11 reset idle", idle, 1);

    // R1 R3 R9 R11: full 8-bit sweep
    for (int b = 0; b < 256; b++) begin
      send(9'(b), 1'b0, 1'b1);
      check(valid == 1, "R1 valid", valid, 1);
      check(data == 8'(b), "R1 data", data, b);
      check(bit9 == 0, "R3 bit9 zero in 8-bit", bit9, 0);
      check(ferr == 0, "R9 no ferr", ferr, 0);
      if (b == 85) check(mid_idle == 0, "R11 busy", mid_idle, 0);
      pop_one();
      check(valid == 0, "R5 empty after pop", valid, 0);
    end
    check(idle == 1, "R11 idle after frames", idle, 1);

    // R3: 9-bit sweep
    nine_bit = 1'b1;
    for (int v = 0; v < 64; v++) begin
      logic [8:0] w;
      w = 9'((v * 37) ^ (v << 3));
      send(w, 1'b1, 1'b1);
      check(data == w[7:0], "R3 low bits", data, w[7:0]);
      check(bit9 == w[8], "R3 ninth bit", bit9, w[8]);
      pop_one();
    end

    // R4: address detect
    addr_det = 1'b1;
    send(9'h0A5, 1'b1, 1'b1);
    check(valid == 0, "R4 drop ninth=0", valid, 0);
    send(9'h13C, 1'b1, 1'b1);
    check(valid == 1 && data == 8'h3C, "R4 pass ninth=1", data, 8'h3C);
    pop_one();
    addr_det = 1'b0;
    send(9'h05A, 1'b1, 1'b1);
    check(valid == 1 && data == 8'h5A && bit9 == 0, "R4 filter off", data, 8'h5A);
    pop_one();
    nine_bit = 1'b0;

    // R5 R6: order and irq
    send(9'h11, 1'b0, 1'b1);
    check(irq == 0, "R6 irq masked", irq, 0);
    rx_ie = 1'b1;
    @(negedge clk);
    check(irq == 1, "R6 irq raised", irq, 1);
    send(9'h22, 1'b0, 1'b1);
    check(data == 8'h11, "R5 head first", data, 8'h11);
    pop_one();
    check(valid == 1 && data == 8'h22, "R5 second", data, 8'h22);
    pop_one();
    check(valid == 0 && irq == 0, "R6 irq drops empty", irq, 0);
    rx_ie = 1'b0;

    // R7 R8: overrun
    send(9'h31, 1'b0, 1'b1);
    send(9'h32, 1'b0, 1'b1);
    check(overrun == 0, "R7 two fit", overrun, 0);
    send(9'h33, 1'b0, 1'b1);
    check(overrun == 1, "R7 overrun set", overrun, 1);
    send(9'h34, 1'b0, 1'b1);
    check(data == 8'h31, "R7 head kept", data, 8'h31);
    pop_one();
    check(data == 8'h32, "R7 second kept", data, 8'h32);
    pop_one();
    check(valid == 0, "R7 extras dropped", valid, 0);
    check(overrun == 1, "R8 sticky", overrun, 1);
    send(9'h35, 1'b0, 1'b1);
    check(valid == 0, "R7 drop while overrun", valid, 0);
    rx_en = 1'b0;
    repeat (2) @(negedge clk);
    check(overrun == 0, "R8 cleared", overrun, 0);
    rx_en = 1'b1;
    send(9'h36, 1'b0, 1'b1);
    check(valid == 1 && data == 8'h36, "R8 resumes", data, 8'h36);
    pop_one();

    // R9: framing error
    send(9'h47, 1'b0, 1'b0);
    hold(1'b1, 32);
    check(valid == 1 && ferr == 1 && data == 8'h47, "R9 ferr set", ferr, 1);
    pop_one();
    check(valid == 0, "R9 no stray char", valid, 0);

    // R10: glitch
    hold(1'b0, 3);
    hold(1'b1, 3);
    check(idle == 0, "R11 start seen", idle, 0);
    hold(1'b1, 30);
    check(idle == 1 && valid == 0, "R10 glitch rejected", valid, 0);

    // R2: enable gating
    port_en = 1'b0;
    send(9'h55, 1'b0, 1'b1);
    check(valid == 0 && mid_idle == 1, "R2 port off", valid, 0);
    port_en = 1'b1; sync_mode = 1'b1;
    send(9'h56, 1'b0, 1'b1);
    check(valid == 0 && mid_idle == 1, "R2 sync mode", valid, 0);
    sync_mode = 1'b0; rx_en = 1'b0;
    send(9'h57, 1'b0, 1'b1);
    check(valid == 0 && mid_idle == 1, "R2 rx off", valid, 0);
    rx_en = 1'b1;
    send(9'h58, 1'b0, 1'b1);
    check(valid == 1 && data == 8'h58, "R2 enabled", data, 8'h58);

    summary();
  end
endmodule